// File: doc/BRIEF.md
# Bit-Serial Attention Score Lane with Interval Guard

This block is one lane of an attention score engine. It holds a group of keys and builds each key's dot product with one query row, one key bit-plane per round. Planes arrive most significant first. Each round adds, for every key still in play, the sum of the query elements whose key bit is set, scaled by the weight of that plane. After adding, the lane publishes a lower bound for every live key (its partial score plus the smallest contribution the unseen planes could still add). It then waits for a broadcast threshold that an outside max-reduction unit derives from those bounds.

When the threshold arrives, each key falls into one of three classes. A key whose best possible final score cannot rise above the threshold is dropped for good, and its score stops changing. A key whose worst possible final score is already above the threshold may be accepted early, if that option is on. Accepted keys keep adding planes, so their final scores are exact; they only skip later drop checks. All other keys stay undecided. After the round for plane 0, every key that was never dropped is reported as a survivor. Its score then equals the full-precision dot product.

Top module: `bsl_score_lane`

## Requirements
- R1: After reset, `done_o`, `lb_valid_o`, `pruned_o`, `accepted_o` and `survivor_o` are all low.
- R2: A cycle with `start_i` high captures `query_i`, clears every score to zero and clears the dropped and accepted masks. In the next cycle the lane waits for a plane, with `done_o` and `lb_valid_o` low.
- R3: Key k, element e sits at bit `k*VEC_LEN+e` of `plane_bits_i`, and query element e at bits `e*QW +: QW` (signed). A plane's increment is the sum of the query elements whose bit is 1. Plane `KEY_BITS-1` is weighted by -2^(KEY_BITS-1) and plane j<`KEY_BITS-1` by +2^j. A key never dropped ends with its exact signed dot product.
- R4: The cycle after a plane is taken, `lb_valid_o` is high. Each live key's `lb_o` slice is its score plus `bound_lo_i`, and a dropped key's slice is the most negative SW-bit value.
- R5: While `lb_valid_o` is high and `threshold_valid_i` is low, scores, masks and `lb_valid_o` hold, and `plane_valid_i` is ignored.
- R6: On `threshold_valid_i`, a live key that is not accepted and whose score plus `bound_hi_i` is at or below `threshold_i` is dropped. A dropped key stays dropped and its score is frozen.
- R7: On `threshold_valid_i` with `early_accept_en_i` high, a live key that is not accepted and not dropped this round, and whose score plus `bound_lo_i` is above `threshold_i`, becomes accepted. An accepted key is never dropped and keeps accumulating.
- R8: With `early_accept_en_i` low, no key becomes accepted.
- R9: After the threshold of the round with `plane_idx_i` = 0, `done_o` rises and `survivor_o` is the complement of the dropped mask. Both hold until the next start.
- R10: When the bounds cover the real range of the unseen planes, no key whose full dot product exceeds the last threshold is ever dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new key group |
| early_accept_en_i | input | 1 | Allow early acceptance at decision time |
| query_i | input | VEC_LEN*QW | Query row, signed elements |
| plane_valid_i | input | 1 | A key bit-plane is presented |
| plane_bits_i | input | NUM_KEYS*VEC_LEN | One bit per key element for this plane |
| plane_idx_i | input | IDXW | Bit position of the presented plane |
| bound_lo_i | input | SW | Smallest contribution of the planes still unseen |
| bound_hi_i | input | SW | Largest contribution of the planes still unseen |
| threshold_valid_i | input | 1 | Broadcast threshold is present |
| threshold_i | input | SW | Broadcast threshold, signed |
| lb_valid_o | output | 1 | Lower bounds published, waiting for threshold |
| lb_o | output | NUM_KEYS*SW | Per-key lower bound, signed |
| score_o | output | NUM_KEYS*SW | Per-key partial or final score, signed |
| pruned_o | output | NUM_KEYS | Keys dropped so far |
| accepted_o | output | NUM_KEYS | Keys accepted early |
| done_o | output | 1 | All planes consumed and decided |
| survivor_o | output | NUM_KEYS | Keys never dropped, valid with done_o |

## Verification
The hardest case to reach is a key dropped in the middle of a group. Reaching it needs a threshold tight enough to cut some keys while the others carry on. The bench then has to see that the dropped score froze at its partial value and did not move on to the exact dot product. The bench derives each threshold from its own model of the published lower bounds, minus a chosen margin. A small margin drops many keys early, and a very low or very high fixed threshold gives the two extremes (nobody dropped, everybody dropped at the first plane). A stalled decision window with stray plane pulses shows that the lane holds still while it waits.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PLANE  = 2'd1,
        ST_THRESH = 2'd2,
        ST_DONE   = 2'd3
    } lane_state_e;

endpackage

// File: rtl/bsl_plane_sum.sv
// Gated adder tree: sums the query elements selected by one key's plane bits.
module bsl_plane_sum #(
    parameter int VEC_LEN = 8,
    parameter int QW      = 8,
    parameter int IW      = 12
) (
    input  logic [VEC_LEN*QW-1:0] query_i,
    input  logic [VEC_LEN-1:0]    key_bits_i,
    output logic signed [IW-1:0]  inc_o
);

    logic signed [IW-1:0] gated [VEC_LEN];

    for (genvar e = 0; e < VEC_LEN; e++) begin : g_gate
        logic signed [QW-1:0] elem;
        assign elem     = query_i[e*QW +: QW];
        assign gated[e] = key_bits_i[e] ? IW'(elem) : '0;
    end

    always_comb begin
        inc_o = '0;
        for (int e = 0; e < VEC_LEN; e++) begin
            inc_o = inc_o + gated[e];
        end
    end

endmodule

// File: rtl/bsl_key_guard.sv
// Per-key three-way classification against the broadcast threshold.
module bsl_key_guard #(
    parameter int SW = 20
) (
    input  logic [SW-1:0] score_i,
    input  logic          pruned_i,
    input  logic          accepted_i,
    input  logic [SW-1:0] lo_i,
    input  logic [SW-1:0] hi_i,
    input  logic [SW-1:0] thr_i,
    input  logic          early_en_i,
    input  logic          apply_i,
    output logic          prune_now_o,
    output logic          accept_now_o,
    output logic [SW-1:0] lb_o
);

    localparam logic [SW-1:0] MOST_NEG = {1'b1, {(SW-1){1'b0}}};

    logic signed [SW:0] upper_x;
    logic signed [SW:0] lower_x;
    logic signed [SW:0] thr_x;
    logic               checking;

    always_comb begin
        upper_x  = $signed({score_i[SW-1], score_i}) + $signed({hi_i[SW-1], hi_i});
        lower_x  = $signed({score_i[SW-1], score_i}) + $signed({lo_i[SW-1], lo_i});
        thr_x    = $signed({thr_i[SW-1], thr_i});
        checking = apply_i && !pruned_i && !accepted_i;

        prune_now_o  = checking && (upper_x <= thr_x);
        accept_now_o = checking && early_en_i && !prune_now_o && (lower_x > thr_x);
        lb_o         = pruned_i ? MOST_NEG : lower_x[SW-1:0];
    end

endmodule

// File: rtl/bsl_score_lane.sv
module bsl_score_lane #(
    parameter int NUM_KEYS = 32,
    parameter int VEC_LEN  = 8,
    parameter int QW       = 8,
    parameter int KEY_BITS = 8,
    localparam int IW      = QW + $clog2(VEC_LEN) + 1,
    localparam int SW      = QW + KEY_BITS + $clog2(VEC_LEN) + 1,
    localparam int IDXW    = $clog2(KEY_BITS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        early_accept_en_i,
    input  logic [VEC_LEN*QW-1:0]       query_i,
    input  logic                        plane_valid_i,
    input  logic [NUM_KEYS*VEC_LEN-1:0] plane_bits_i,
    input  logic [IDXW-1:0]             plane_idx_i,
    input  logic [SW-1:0]               bound_lo_i,
    input  logic [SW-1:0]               bound_hi_i,
    input  logic                        threshold_valid_i,
    input  logic [SW-1:0]               threshold_i,
    output logic                        lb_valid_o,
    output logic [NUM_KEYS*SW-1:0]      lb_o,
    output logic [NUM_KEYS*SW-1:0]      score_o,
    output logic [NUM_KEYS-1:0]         pruned_o,
    output logic [NUM_KEYS-1:0]         accepted_o,
    output logic                        done_o,
    output logic [NUM_KEYS-1:0]         survivor_o
);
    import bsl_pkg::*;

    localparam logic [IDXW-1:0] TOP_PLANE = IDXW'(KEY_BITS - 1);

    typedef struct packed {
        lane_state_e                    st;
        logic [NUM_KEYS-1:0][SW-1:0]    score;
        logic [NUM_KEYS-1:0]            pruned;
        logic [NUM_KEYS-1:0]            accepted;
        logic [IDXW-1:0]                idx;
        logic [SW-1:0]                  lo;
        logic [SW-1:0]                  hi;
        logic [VEC_LEN*QW-1:0]          query;
    } lane_regs_t;

    lane_regs_t lane_d, lane_q;

    logic signed [SW-1:0] delta     [NUM_KEYS];
    logic [NUM_KEYS-1:0]  prune_now;
    logic [NUM_KEYS-1:0]  accept_now;
    logic                 apply;

    assign apply = (lane_q.st == ST_THRESH) && threshold_valid_i;

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        logic signed [IW-1:0] inc;
        logic signed [SW-1:0] ext;
        logic signed [SW-1:0] shifted;

        bsl_plane_sum #(
            .VEC_LEN (VEC_LEN),
            .QW      (QW),
            .IW      (IW)
        ) sum_i (
            .query_i    (lane_q.query),
            .key_bits_i (plane_bits_i[k*VEC_LEN +: VEC_LEN]),
            .inc_o      (inc)
        );

        always_comb begin
            ext      = SW'(inc);
            shifted  = ext <<< plane_idx_i;
            delta[k] = (plane_idx_i == TOP_PLANE) ? -shifted : shifted;
        end

        bsl_key_guard #(
            .SW (SW)
        ) guard_i (
            .score_i      (lane_q.score[k]),
            .pruned_i     (lane_q.pruned[k]),
            .accepted_i   (lane_q.accepted[k]),
            .lo_i         (lane_q.lo),
            .hi_i         (lane_q.hi),
            .thr_i        (threshold_i),
            .early_en_i   (early_accept_en_i),
            .apply_i      (apply),
            .prune_now_o  (prune_now[k]),
            .accept_now_o (accept_now[k]),
            .lb_o         (lb_o[k*SW +: SW])
        );

        assign score_o[k*SW +: SW] = lane_q.score[k];
    end

    always_comb begin
        lane_d = lane_q;
        unique case (lane_q.st)
            ST_PLANE: begin
                if (plane_valid_i) begin
                    for (int k = 0; k < NUM_KEYS; k++) begin
                        if (!lane_q.pruned[k]) begin
                            lane_d.score[k] = lane_q.score[k] + delta[k];
                        end
                    end
                    lane_d.idx = plane_idx_i;
                    lane_d.lo  = bound_lo_i;
                    lane_d.hi  = bound_hi_i;
                    lane_d.st  = ST_THRESH;
                end
            end
            ST_THRESH: begin
                if (threshold_valid_i) begin
                    lane_d.pruned   = lane_q.pruned | prune_now;
                    lane_d.accepted = lane_q.accepted | accept_now;
                    lane_d.st       = (lane_q.idx == '0) ? ST_DONE : ST_PLANE;
                end
            end
            default: ;
        endcase
        if (start_i) begin
            lane_d.st       = ST_PLANE;
            lane_d.score    = '0;
            lane_d.pruned   = '0;
            lane_d.accepted = '0;
            lane_d.query    = query_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '{st: ST_IDLE, default: '0};
        end else begin
            lane_q <= lane_d;
        end
    end

    assign lb_valid_o = (lane_q.st == ST_THRESH);
    assign done_o     = (lane_q.st == ST_DONE);
    assign pruned_o   = lane_q.pruned;
    assign accepted_o = lane_q.accepted;
    assign survivor_o = done_o ? ~lane_q.pruned : '0;

endmodule

// File: rtl/bsl_score_lane_chk.sv
module bsl_score_lane_chk #(
    parameter int NUM_KEYS = 32,
    parameter int SW       = 20
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic                   early_accept_en_i,
    input logic                   threshold_valid_i,
    input logic                   lb_valid_o,
    input logic [NUM_KEYS*SW-1:0] score_o,
    input logic [NUM_KEYS-1:0]    pruned_o,
    input logic [NUM_KEYS-1:0]    accepted_o,
    input logic                   done_o,
    input logic [NUM_KEYS-1:0]    survivor_o
);

    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (pruned_o == '0 && accepted_o == '0 && !done_o && !lb_valid_o));

    p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_valid_o && !threshold_valid_i && !start_i) |=>
        (lb_valid_o && $stable(pruned_o) && $stable(accepted_o) && $stable(score_o)));

    p_prune_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ((pruned_o & $past(pruned_o)) == $past(pruned_o)));

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_frz
        p_frozen_score_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (pruned_o[k] && !start_i) |=> $stable(score_o[k*SW +: SW]));
    end

    p_class_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted_o & pruned_o) == '0);

    p_accept_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!early_accept_en_i && !start_i) |=> ((accepted_o & ~$past(accepted_o)) == '0));

    p_done_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !lb_valid_o);

    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(survivor_o)));

endmodule

bind bsl_score_lane bsl_score_lane_chk #(
    .NUM_KEYS (NUM_KEYS),
    .SW       (SW)
) chk_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .start_i           (start_i),
    .early_accept_en_i (early_accept_en_i),
    .threshold_valid_i (threshold_valid_i),
    .lb_valid_o        (lb_valid_o),
    .score_o           (score_o),
    .pruned_o          (pruned_o),
    .accepted_o        (accepted_o),
    .done_o            (done_o),
    .survivor_o        (survivor_o)
);

// File: tb/bsl_score_lane_tb.sv
module bsl_score_lane_tb_top;
    localparam int NK   = 32;
    localparam int VL   = 8;
    localparam int QW   = 8;
    localparam int KB   = 8;
    localparam int SW   = QW + KB + $clog2(VL) + 1;
    localparam int IDXW = $clog2(KB);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic ea_i = 1'b0;
    logic [VL*QW-1:0] query_i = '0;
    logic plane_valid_i = 1'b0;
    logic [NK*VL-1:0] plane_bits_i = '0;
    logic [IDXW-1:0] plane_idx_i = '0;
    logic [SW-1:0] bound_lo_i = '0, bound_hi_i = '0;
    logic threshold_valid_i = 1'b0;
    logic [SW-1:0] threshold_i = '0;
    logic lb_valid_o, done_o;
    logic [NK*SW-1:0] lb_o, score_o;
    logic [NK-1:0] pruned_o, accepted_o, survivor_o;

    always #5 clk = ~clk;

    bsl_score_lane #(.NUM_KEYS(NK), .VEC_LEN(VL), .QW(QW), .KEY_BITS(KB)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .early_accept_en_i(ea_i),
        .query_i(query_i), .plane_valid_i(plane_valid_i), .plane_bits_i(plane_bits_i),
        .plane_idx_i(plane_idx_i), .bound_lo_i(bound_lo_i), .bound_hi_i(bound_hi_i),
        .threshold_valid_i(threshold_valid_i), .threshold_i(threshold_i),
        .lb_valid_o(lb_valid_o), .lb_o(lb_o), .score_o(score_o), .pruned_o(pruned_o),
        .accepted_o(accepted_o), .done_o(done_o), .survivor_o(survivor_o));

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        bit [NK-1:0] surv;
        bit [NK-1:0] acc;
        int          sc[NK];
        int          truth[NK];
        int          thr;
    } exp_t;
    exp_t sbq[$];

    int q[VL];
    int kv[NK][VL];
    int ms[NK];
    bit mp[NK];
    bit ma[NK];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int dut_score(input int j);
        logic signed [SW-1:0] v;
        v = score_o[j*SW +: SW];
        return int'(v);
    endfunction

    function automatic int dut_lb(input int j);
        logic signed [SW-1:0] v;
        v = lb_o[j*SW +: SW];
        return int'(v);
    endfunction

    // mode 0: threshold = max live lower bound minus param; mode 1: fixed param
    task automatic run_group(input int mode, input bit ea, input int param, input bit stall);
        exp_t e;
        int thr = 0;
        for (int j = 0; j < NK; j++) begin
            ms[j] = 0; mp[j] = 0; ma[j] = 0;
        end
        @(negedge clk);
        for (int i = 0; i < VL; i++) query_i[i*QW +: QW] = QW'(q[i]);
        ea_i = ea;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(pruned_o == '0 && accepted_o == '0, "R2", "masks after start", int'(pruned_o | accepted_o), 0);
        chk(!done_o && !lb_valid_o, "R2", "flags after start", int'({done_o, lb_valid_o}), 0);
        chk(score_o == '0, "R2", "scores after start", dut_score(0), 0);
        for (int r = KB - 1; r >= 0; r--) begin
            int lo = 0, hi = 0, lbmax;
            bit any;
            for (int i = 0; i < VL; i++) begin
                if (q[i] < 0) lo += q[i] * ((1 << r) - 1);
                else          hi += q[i] * ((1 << r) - 1);
            end
            for (int j = 0; j < NK; j++) begin
                int inc = 0;
                for (int i = 0; i < VL; i++) begin
                    plane_bits_i[j*VL + i] = ((kv[j][i] & 255) >> r) & 1;
                    if (plane_bits_i[j*VL + i]) inc += q[i];
                end
                if (!mp[j]) ms[j] += (r == KB - 1) ? -(inc << r) : (inc << r);
            end
            plane_idx_i = IDXW'(r);
            bound_lo_i = SW'(lo);
            bound_hi_i = SW'(hi);
            plane_valid_i = 1'b1;
            @(negedge clk);
            plane_valid_i = 1'b0;
            chk(lb_valid_o, "R4", "lb_valid after plane", int'(lb_valid_o), 1);
            any = 0; lbmax = 0;
            for (int j = 0; j < NK; j++) begin
                int explb = mp[j] ? -(1 << (SW - 1)) : ms[j] + lo;
                chk(dut_lb(j) == explb, "R4", $sformatf("lb key %0d round %0d", j, r), dut_lb(j), explb);
                if (!mp[j] && (!any || ms[j] + lo > lbmax)) begin
                    lbmax = ms[j] + lo; any = 1;
                end
            end
            if (stall && r == KB - 2) begin
                for (int s = 0; s < 3; s++) begin
                    plane_bits_i = ~plane_bits_i;
                    plane_valid_i = 1'b1;
                    @(negedge clk);
                    plane_valid_i = 1'b0;
                    chk(lb_valid_o, "R5", "still waiting", int'(lb_valid_o), 1);
                    for (int j = 0; j < NK; j++)
                        chk(dut_score(j) == ms[j], "R5", $sformatf("score held key %0d", j), dut_score(j), ms[j]);
                end
            end
            thr = (mode == 0) ? lbmax - param : param;
            for (int j = 0; j < NK; j++) begin
                if (!mp[j] && !ma[j]) begin
                    if (ms[j] + hi <= thr) mp[j] = 1;
                    else if (ea && ms[j] + lo > thr) ma[j] = 1;
                end
            end
            threshold_i = SW'(thr);
            threshold_valid_i = 1'b1;
            @(negedge clk);
            threshold_valid_i = 1'b0;
        end
        for (int j = 0; j < NK; j++) begin
            int t = 0;
            for (int i = 0; i < VL; i++) t += q[i] * kv[j][i];
            e.truth[j] = t;
            e.sc[j] = mp[j] ? ms[j] : t;
            e.surv[j] = !mp[j];
            e.acc[j] = ma[j];
        end
        e.thr = thr;
        sbq.push_back(e);
        while (sbq.size() != 0) @(negedge clk);
    endtask

    // monitor: compare completed groups against expectations
    initial begin
        forever begin
            @(negedge clk);
            if (done_o && sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                chk(survivor_o == e.surv, "R9", "survivor mask", int'(survivor_o), int'(e.surv));
                chk(accepted_o == e.acc, "R7", "accepted mask", int'(accepted_o), int'(e.acc));
                if (!ea_i) chk(accepted_o == '0, "R8", "no accept when off", int'(accepted_o), 0);
                for (int j = 0; j < NK; j++) begin
                    chk(dut_score(j) == e.sc[j], e.surv[j] ? "R3" : "R6",
                        $sformatf("final score key %0d", j), dut_score(j), e.sc[j]);
                    if (e.truth[j] > e.thr)
                        chk(survivor_o[j], "R10", $sformatf("safe key %0d kept", j), int'(survivor_o[j]), 1);
                end
            end
        end
    end

    task automatic fill_random();
        for (int i = 0; i < VL; i++) q[i] = $signed($urandom_range(255, 0)) - 128;
        for (int j = 0; j < NK; j++)
            for (int i = 0; i < VL; i++) kv[j][i] = $signed($urandom_range(255, 0)) - 128;
    endtask

    initial begin
        void'($urandom(7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && !lb_valid_o, "R1", "flags after reset", int'({done_o, lb_valid_o}), 0);
        chk(pruned_o == '0 && accepted_o == '0 && survivor_o == '0, "R1", "masks after reset",
            int'(pruned_o | accepted_o | survivor_o), 0);
        fill_random();
        run_group(0, 1'b1, 3000, 1'b1);
        fill_random();
        run_group(0, 1'b0, 500, 1'b0);
        fill_random();
        run_group(1, 1'b0, -(1 << (SW - 1)), 1'b0);
        for (int i = 0; i < VL; i++) q[i] = 127;
        for (int j = 0; j < NK; j++)
            for (int i = 0; i < VL; i++) kv[j][i] = (j % 2 == 0) ? -128 : 127 - j;
        run_group(0, 1'b1, 1, 1'b0);
        fill_random();
        run_group(1, 1'b1, 200000, 1'b0);
        fill_random();
        run_group(0, 1'b1, 20000, 1'b1);
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule